// File: doc/BRIEF.md
# Shared-Line Multi-Converter Readout Controller

This block is the host-side sequencer for a group of serial successive-approximation converters that share three wires: one convert strobe, one serial clock and one serial data line. A single start request makes the controller raise the common convert strobe, so every converter samples at the same instant. It then waits until the converters report that conversion has finished by dropping the common busy signal.

Once busy is low, the controller walks the converters in index order. For each one it pulls that converter's own active-low read-enable line low, keeps the serial clock low through a guard window while the device places its top bit on the shared line, and then clocks out the remaining bits, most significant first. Between two devices every read-enable is high and the serial clock stays low for at least one full serial clock period. Each finished word leaves the block with its device index and a one-cycle valid strobe. A done strobe follows the last device. If busy never falls, a timeout ends the sequence and raises an error strobe.

Top module: `adc_bus_reader`

## Requirements
- R1: An accepted start drives `cnv_o` high for exactly CNV_HIGH (default 3) system clock cycles, once per sequence.
- R2: No read-enable line is low while `cnv_o` is high or while the converters report busy before readout. Readout begins only after `busy_i` has been seen high and then low.
- R3: At most one bit of `rdl_n_o` is low in any cycle. All bits idle high.
- R4: `sck_o` is low in the cycle a read-enable falls. It stays low for at least ceil(GUARD_NS/CLK_PERIOD_NS) system cycles after the fall (16 ns; 4 cycles at the 4 ns default).
- R5: Each selected device receives exactly WORD_W (16) rising `sck_o` edges. The word is assembled MSB first: bit 15 is taken from `sdo_i` at the end of the guard window, and each further bit is taken just before the next rising edge, after the device has moved on.
- R6: After a word, the read-enable rises and all lines stay high, with `sck_o` low, for at least 2*SCK_HALF system cycles (one serial clock period) before the next device is selected. Devices are selected in index order 0, 1, ..., N_DEV-1. `sck_o` never toggles while no device is selected.
- R7: Each word appears on `word_o` with its device index on `word_ch_o` and a one-cycle `word_valid_o` pulse. One word is produced per device.
- R8: `done_o` pulses for one cycle after the last device's word, once per sequence.
- R9: A start that arrives during the convert pulse, the busy wait or the readout is ignored. It produces no second convert pulse and no extra words.
- R10: If `busy_i` has not completed its high-then-low sequence within BUSY_TMO cycles after the convert pulse, `timeout_err_o` pulses for one cycle. No device is selected, and the block returns to idle and accepts the next start.
- R11: While `rst` is high and right after it: `cnv_o` and `sck_o` are low, all `rdl_n_o` bits are high, and `word_valid_o`, `done_o` and `timeout_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one convert-and-read sequence |
| busy_i | input | 1 | Common busy from the converters, high while converting |
| sdo_i | input | 1 | Shared serial data line |
| cnv_o | output | 1 | Common convert strobe |
| sck_o | output | 1 | Shared serial clock |
| rdl_n_o | output | N_DEV | Per-device read-enable, active low |
| word_o | output | WORD_W | Last completed result word |
| word_ch_o | output | ceil(log2 N_DEV) | Device index of `word_o` |
| word_valid_o | output | 1 | One-cycle strobe for `word_o` |
| done_o | output | 1 | One-cycle strobe after the last device |
| timeout_err_o | output | 1 | One-cycle strobe when busy never completes |

## Verification
The hardest states to reach from the ports are the busy timeout and a start request that lands in the middle of a device read. The bench's converter model can hold busy high on command, which drives the controller into the timeout branch. A normal sequence follows to show that it recovers. In another run, extra start pulses are placed during the busy wait and again while a read-enable is low. The bench then counts convert edges, words and done pulses. The guard window and the gap between devices are measured at the pins on every select edge of every run.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT,
        ST_GUARD,
        ST_SHIFT,
        ST_GAP
    } rd_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // bits needed to hold the values 0..n
    function automatic int width_for(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // bits needed to index n items
    function automatic int idx_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/adc_rd_sck_gen.sv
module adc_rd_sck_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sck,
    output logic rise_now,
    output logic fall_now
);
    localparam int CW = adc_rd_pkg::width_for(HALF);

    logic [CW-1:0] ph_cnt;
    logic          ph_end;

    assign ph_end   = (ph_cnt == CW'(HALF - 1));
    // strobes announce what sck does at the coming edge
    assign rise_now = run && ph_end && !sck;
    assign fall_now = run && ph_end && sck;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph_cnt <= '0;
            sck    <= 1'b0;
        end else if (ph_end) begin
            ph_cnt <= '0;
            sck    <= ~sck;
        end else begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[W-2:0], din};
        end
    end
endmodule

// File: rtl/adc_rd_select.sv
module adc_rd_select #(
    parameter int N  = 3,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] idx,
    output logic [N-1:0]  sel_n
);
    for (genvar g = 0; g < N; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_n[g] <= 1'b1;
            end else begin
                sel_n[g] <= !(en && (idx == CW'(g)));
            end
        end
    end
endmodule

// File: rtl/adc_bus_reader.sv
module adc_bus_reader
    import adc_rd_pkg::*;
#(
    parameter int N_DEV         = 3,
    parameter int WORD_W        = 16,
    parameter int SCK_HALF      = 2,
    parameter int CLK_PERIOD_NS = 4,
    parameter int GUARD_NS      = 16,
    parameter int CNV_HIGH      = 3,
    parameter int BUSY_TMO      = 200
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start_i,
    input  logic                               busy_i,
    input  logic                               sdo_i,
    output logic                               cnv_o,
    output logic                               sck_o,
    output logic [N_DEV-1:0]                   rdl_n_o,
    output logic [WORD_W-1:0]                  word_o,
    output logic [adc_rd_pkg::idx_width(N_DEV)-1:0] word_ch_o,
    output logic                               word_valid_o,
    output logic                               done_o,
    output logic                               timeout_err_o
);
    localparam int CH_W      = idx_width(N_DEV);
    localparam int GUARD_CYC = max_i(1, ceil_div(GUARD_NS, CLK_PERIOD_NS));
    localparam int GAP_CYC   = 2 * SCK_HALF;
    localparam int CNT_W     = width_for(max_i(max_i(BUSY_TMO, GUARD_CYC),
                                               max_i(CNV_HIGH, GAP_CYC)));
    localparam int EDG_W     = width_for(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [CH_W-1:0]   ch;
    } result_t;

    rd_state_e        st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CH_W-1:0]  dev, dev_n;
    logic [EDG_W-1:0] edg, edg_n;
    logic             seen, seen_n;

    logic             cap, clr, emit, fin, tmo;
    logic             sck_run, rise_now, fall_now;
    logic [WORD_W-1:0] shreg;
    logic             sel_en;

    result_t          res_q;
    logic             valid_q, done_q, err_q, cnv_q;

    // ------------------------------------------------------------------
    // sequencing
    // ------------------------------------------------------------------
    always_comb begin
        st_n   = st;
        cnt_n  = cnt + 1'b1;
        dev_n  = dev;
        edg_n  = edg;
        seen_n = seen;
        cap    = 1'b0;
        clr    = 1'b0;
        emit   = 1'b0;
        fin    = 1'b0;
        tmo    = 1'b0;
        case (st)
            ST_IDLE: begin
                cnt_n = '0;
                if (start_i) begin
                    st_n   = ST_CONV;
                    seen_n = 1'b0;
                end
            end
            ST_CONV: begin
                seen_n = seen | busy_i;
                if (cnt == CNT_W'(CNV_HIGH - 1)) begin
                    st_n  = ST_WAIT;
                    cnt_n = '0;
                end
            end
            ST_WAIT: begin
                seen_n = seen | busy_i;
                if (seen && !busy_i) begin
                    st_n  = ST_GUARD;
                    cnt_n = '0;
                    dev_n = '0;
                    clr   = 1'b1;
                end else if (cnt == CNT_W'(BUSY_TMO - 1)) begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                    tmo   = 1'b1;
                end
            end
            ST_GUARD: begin
                if (cnt == CNT_W'(GUARD_CYC - 1)) begin
                    st_n  = ST_SHIFT;
                    cnt_n = '0;
                    edg_n = '0;
                    cap   = 1'b1;   // top bit is already on the line
                end
            end
            ST_SHIFT: begin
                cnt_n = '0;
                if (rise_now) begin
                    edg_n = edg + 1'b1;
                    cap   = (edg != '0);
                end
                if (fall_now && (edg == EDG_W'(WORD_W))) begin
                    st_n = ST_GAP;
                    emit = 1'b1;
                end
            end
            ST_GAP: begin
                if (cnt == CNT_W'(GAP_CYC - 1)) begin
                    cnt_n = '0;
                    if (dev == CH_W'(N_DEV - 1)) begin
                        st_n = ST_IDLE;
                        fin  = 1'b1;
                    end else begin
                        st_n  = ST_GUARD;
                        dev_n = dev + 1'b1;
                        clr   = 1'b1;
                    end
                end
            end
            default: begin
                st_n  = ST_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            dev  <= '0;
            edg  <= '0;
            seen <= 1'b0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            dev  <= dev_n;
            edg  <= edg_n;
            seen <= seen_n;
        end
    end

    // ------------------------------------------------------------------
    // serial clock, capture and select
    // ------------------------------------------------------------------
    assign sck_run = (st == ST_SHIFT);

    adc_rd_sck_gen #(
        .HALF (SCK_HALF)
    ) u_sck (
        .clk      (clk),
        .rst      (rst),
        .run      (sck_run),
        .sck      (sck_o),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    adc_rd_shifter #(
        .W (WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (clr),
        .shift_en (cap),
        .din      (sdo_i),
        .word     (shreg)
    );

    assign sel_en = (st_n == ST_GUARD) || (st_n == ST_SHIFT);

    adc_rd_select #(
        .N  (N_DEV),
        .CW (CH_W)
    ) u_sel (
        .clk   (clk),
        .rst   (rst),
        .en    (sel_en),
        .idx   (dev_n),
        .sel_n (rdl_n_o)
    );

    // ------------------------------------------------------------------
    // result and strobes
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            cnv_q   <= 1'b0;
        end else begin
            valid_q <= emit;
            done_q  <= fin;
            err_q   <= tmo;
            cnv_q   <= (st_n == ST_CONV);
            if (emit) begin
                res_q.data <= shreg;
                res_q.ch   <= dev;
            end
        end
    end

    assign cnv_o         = cnv_q;
    assign word_o        = res_q.data;
    assign word_ch_o     = res_q.ch;
    assign word_valid_o  = valid_q;
    assign done_o        = done_q;
    assign timeout_err_o = err_q;

endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker #(
    parameter int N_DEV     = 3,
    parameter int WORD_W    = 16,
    parameter int SCK_HALF  = 2,
    parameter int GUARD_CYC = 4,
    parameter int CNV_HIGH  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cnv_o,
    input logic             sck_o,
    input logic [N_DEV-1:0] rdl_n_o,
    input logic             word_valid_o,
    input logic             done_o,
    input logic             timeout_err_o
);
    localparam int GAP_CYC = 2 * SCK_HALF;

    logic        all_hi;
    logic        sck_d;
    int unsigned hi_len, g_cnt, idle_cnt, rise_cnt;

    assign all_hi = &rdl_n_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len   <= 0;
            g_cnt    <= 0;
            idle_cnt <= GAP_CYC;
            rise_cnt <= 0;
            sck_d    <= 1'b0;
        end else begin
            sck_d  <= sck_o;
            hi_len <= cnv_o ? hi_len + 1 : 0;
            if (all_hi) g_cnt <= 0;
            else if (g_cnt < GUARD_CYC) g_cnt <= g_cnt + 1;
            if (!all_hi) idle_cnt <= 0;
            else if (idle_cnt < GAP_CYC) idle_cnt <= idle_cnt + 1;
            if (all_hi) rise_cnt <= 0;
            else if (sck_o && !sck_d) rise_cnt <= rise_cnt + 1;
        end
    end

    p_cnv_width_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(cnv_o) |-> (hi_len == CNV_HIGH));

    p_quiet_convert_r2: assert property (@(posedge clk) disable iff (rst)
        cnv_o |-> all_hi);

    p_one_select_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~rdl_n_o));

    p_sck_low_at_select_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(all_hi) |-> (!sck_o && !$past(sck_o)));

    p_guard_window_r4: assert property (@(posedge clk) disable iff (rst)
        (!all_hi && (g_cnt < GUARD_CYC)) |-> !sck_o);

    p_edge_count_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(all_hi) |-> (rise_cnt == WORD_W));

    p_gap_between_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(all_hi) |-> (idle_cnt >= GAP_CYC));

    p_sck_idle_r6: assert property (@(posedge clk) disable iff (rst)
        all_hi |-> !sck_o);

    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |=> !word_valid_o);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_timeout_idle_r10: assert property (@(posedge clk) disable iff (rst)
        timeout_err_o |-> (all_hi && !cnv_o));

endmodule

bind adc_bus_reader adc_rd_checker #(
    .N_DEV     (N_DEV),
    .WORD_W    (WORD_W),
    .SCK_HALF  (SCK_HALF),
    .GUARD_CYC (GUARD_CYC),
    .CNV_HIGH  (CNV_HIGH)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cnv_o         (cnv_o),
    .sck_o         (sck_o),
    .rdl_n_o       (rdl_n_o),
    .word_valid_o  (word_valid_o),
    .done_o        (done_o),
    .timeout_err_o (timeout_err_o)
);

// File: tb/adc_bus_reader_test.sv
module adc_bus_reader_test;
    localparam int NDEV     = 3;
    localparam int WW       = 16;
    localparam int HALF     = 2;
    localparam int CLK_NS   = 4;
    localparam int GUARD_NS = 16;
    localparam int CNVH     = 3;
    localparam int TMO      = 200;
    localparam int CONV_CYC = 40;
    localparam int NVEC     = 4;

    // each entry: {device2, device1, device0}
    localparam logic [3*WW-1:0] VEC [NVEC] = '{
        {16'hA5C3, 16'h7FFE, 16'h8001},
        {16'h1234, 16'hFFFF, 16'h0000},
        {16'h8000, 16'h0000, 16'hFFFF},
        {16'hC0DE, 16'h5A5A, 16'h0001}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic            busy;
    logic            sdo;
    logic            cnv, sck, wvalid, done, err;
    logic [NDEV-1:0] rdl_n;
    logic [WW-1:0]   word;
    logic [1:0]      wch;

    always #2 clk = ~clk;

    adc_bus_reader uut (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .busy_i        (busy),
        .sdo_i         (sdo),
        .cnv_o         (cnv),
        .sck_o         (sck),
        .rdl_n_o       (rdl_n),
        .word_o        (word),
        .word_ch_o     (wch),
        .word_valid_o  (wvalid),
        .done_o        (done),
        .timeout_err_o (err)
    );

    // ---------------- converter model ----------------
    logic [WW-1:0] dev_data [NDEV];
    int            ptr;
    logic          sck_prev, cnv_prev, busy_hold;
    int            conv_left;

    always @* begin
        sdo = 1'b1;
        for (int k = 0; k < NDEV; k++)
            if (!rdl_n[k] && ptr >= 0) sdo = dev_data[k][ptr];
    end

    always @(posedge clk) begin
        sck_prev <= sck;
        cnv_prev <= cnv;
        if (&rdl_n) ptr <= WW - 1;
        else if (sck && !sck_prev) ptr <= ptr - 1;
        if (rst) begin
            busy      <= 1'b0;
            conv_left <= 0;
        end else if (cnv && !cnv_prev) begin
            busy      <= 1'b1;
            conv_left <= CONV_CYC;
        end else if (busy && !busy_hold) begin
            if (conv_left <= 1) busy <= 1'b0;
            conv_left <= conv_left - 1;
        end
    end

    // ---------------- pin monitors ----------------
    int checks = 0, errors = 0;
    int nwords, ncnv, ndone, nerr, nsel;
    logic [WW-1:0] got_d [8];
    int            got_c [8];
    int multi_sel = 0, sel_busy = 0, edges_bad = 0, sck_idle = 0;
    int min_guard = 1000, min_gap = 1000, cnv_w = 0, last_cnv_w = 0;
    int sel_age = 0, idle_age = 1000, rises_this = 0;
    logic m_sck_prev = 1'b0, m_all_prev = 1'b1, m_cnv_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (wvalid) begin
                if (nwords < 8) begin
                    got_d[nwords] = word;
                    got_c[nwords] = int'(wch);
                end
                nwords++;
            end
            if (done) ndone++;
            if (err) nerr++;
            if (cnv && !m_cnv_prev) ncnv++;
            if (cnv) cnv_w++;
            else if (m_cnv_prev) begin
                last_cnv_w = cnv_w;
                cnv_w = 0;
            end
            if ($countones(~rdl_n) > 1) multi_sel++;
            if (!(&rdl_n) && (busy || cnv)) sel_busy++;
            if ((&rdl_n) && sck) sck_idle++;
            if (&rdl_n) begin
                if (!m_all_prev) begin
                    if (rises_this != WW) edges_bad++;
                    rises_this = 0;
                end
                sel_age = 0;
                idle_age++;
            end else begin
                if (m_all_prev) begin
                    nsel++;
                    if (idle_age < min_gap) min_gap = idle_age;
                    idle_age = 0;
                end
                sel_age++;
                if (sck && !m_sck_prev) begin
                    if (rises_this == 0 && sel_age < min_guard) min_guard = sel_age;
                    rises_this++;
                end
            end
            m_sck_prev = sck;
            m_all_prev = &rdl_n;
            m_cnv_prev = cnv;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        nwords = 0; ncnv = 0; ndone = 0; nerr = 0; nsel = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end(input int limit);
        for (int c = 0; c < limit; c++) begin
            @(negedge clk);
            if (ndone > 0 || nerr > 0) break;
        end
    endtask

    task automatic run_seq(input logic [3*WW-1:0] v, input bit inject);
        for (int k = 0; k < NDEV; k++) dev_data[k] = v[k*WW +: WW];
        clear_counts();
        pulse_start();
        if (inject) begin
            // R9: start during busy wait, then during a device read
            repeat (6) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
            while (&rdl_n) @(negedge clk);
            repeat (10) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        wait_end(3000);
    endtask

    task automatic check_words(input logic [3*WW-1:0] v, input string tag);
        chk(nwords == NDEV, "R7", {tag, " word count"}, nwords, NDEV);
        for (int k = 0; k < NDEV; k++) begin
            chk(got_d[k] == v[k*WW +: WW], "R5", {tag, " word data"}, got_d[k], v[k*WW +: WW]);
            chk(got_c[k] == k, "R6", {tag, " device order"}, got_c[k], k);
        end
        chk(ndone == 1, "R8", {tag, " done pulses"}, ndone, 1);
        chk(ncnv == 1, "R1", {tag, " convert pulses"}, ncnv, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        busy_hold = 1'b0;
        for (int k = 0; k < NDEV; k++) dev_data[k] = '0;
        clear_counts();
        repeat (4) @(negedge clk);
        // R11: reset state, during reset
        chk(cnv == 1'b0, "R11", "cnv in reset", cnv, 0);
        chk(sck == 1'b0, "R11", "sck in reset", sck, 0);
        chk(&rdl_n, "R11", "read-enables in reset", rdl_n, {NDEV{1'b1}});
        chk(!wvalid && !done && !err, "R11", "strobes in reset", {wvalid, done, err}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(&rdl_n && !cnv && !sck, "R11", "idle after reset", {cnv, sck, rdl_n}, {2'b00, {NDEV{1'b1}}});

        // vector walk
        for (int i = 0; i < NVEC; i++) begin
            run_seq(VEC[i], i == 1);
            check_words(VEC[i], $sformatf("vec%0d", i));
            chk(last_cnv_w == CNVH, "R1", "convert width", last_cnv_w, CNVH);
            if (i == 1) begin
                repeat (30) @(negedge clk);
                chk(ncnv == 1 && nwords == NDEV, "R9", "starts during activity ignored",
                    ncnv * 16 + nwords, 16 + NDEV);
            end
            repeat (8) @(negedge clk);
        end

        // pin-level timing properties gathered over all runs
        chk(multi_sel == 0, "R3", "cycles with several selects", multi_sel, 0);
        chk(sel_busy == 0, "R2", "selects during convert or busy", sel_busy, 0);
        chk((min_guard - 1) * CLK_NS >= GUARD_NS, "R4", "sck-low ns after select",
            (min_guard - 1) * CLK_NS, GUARD_NS);
        chk(edges_bad == 0, "R5", "devices with wrong edge count", edges_bad, 0);
        chk(min_gap >= 2 * HALF, "R6", "deselect gap cycles", min_gap, 2 * HALF);
        chk(sck_idle == 0, "R6", "sck high with no select", sck_idle, 0);

        // R10: busy never falls
        busy_hold = 1'b1;
        clear_counts();
        pulse_start();
        wait_end(TMO + 100);
        chk(nerr == 1, "R10", "timeout error pulses", nerr, 1);
        chk(nsel == 0 && nwords == 0 && ndone == 0, "R10", "no readout after timeout",
            nsel + nwords + ndone, 0);
        busy_hold = 1'b0;
        repeat (10) @(negedge clk);

        // R10: accepts a new start afterwards
        run_seq(VEC[3], 1'b0);
        check_words(VEC[3], "after-timeout");

        // R2: busy already low and never rising must not start a read
        busy_hold = 1'b0;
        clear_counts();
        force busy = 1'b0;
        pulse_start();
        wait_end(TMO + 100);
        release busy;
        chk(nerr == 1 && nsel == 0, "R2", "no read without busy cycle", nerr * 16 + nsel, 16);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule